// File: doc/BRIEF.md
# Command Output Latch with Inactivity Timeout

This block sits behind an infrared packet receiver. Each time the receiver finishes a packet, it presents a 3-bit command value together with a one-cycle valid strobe. The block decodes four recognized command values, each onto its own output line. It holds the selected line high in a register until another recognized command or a timeout replaces it.

The block also runs an inactivity timer. A periodic tick from the receiver's time base (100 µs in the target system) clocks the timer. The timer is made of two stages. The first stage counts ticks and wraps. The second stage counts those wraps. If no completed packet arrives within a set number of wrap periods, the timer drops every output line and sends a one-cycle clear pulse back to the receiver, so that the receiver discards any partly assembled packet. With the default widths, one wrap period is 256 ticks (25.6 ms) and the timeout is five wrap periods.

Top module: `cmd_latch_timeout`

## Requirements
- R1: During and after synchronous reset, `line_q` is 4'b0000, `rx_clear` is 0, and the timer is disarmed.
- R2: A valid command with code 3'b001 sets `line_q` to 4'b0001, which drives line 0.
- R3: A valid command with code 3'b100 sets `line_q` to 4'b0010, which drives line 1.
- R4: A valid command with code 3'b111 sets `line_q` to 4'b0100, which drives line 2.
- R5: A valid command with code 3'b101 sets `line_q` to 4'b1000, which drives line 3.
- R6: A valid command with any other code (3'b000, 3'b010, 3'b011 or 3'b110) leaves `line_q` unchanged. It still restarts and arms the timer, in the same way as a recognized command.
- R7: A recognized command replaces the previous pattern, so at most one bit of `line_q` is ever high.
- R8: The timer advances only on cycles where `tick` is high and the timer is armed. Ticks that arrive after reset, or after a timeout, have no effect. The timeout fires on the TIMEOUT_PERIODS × 2^TICK_W-th armed tick counted from the last valid command.
- R9: When the timeout fires, `line_q` becomes 4'b0000 and `rx_clear` is high for exactly one cycle, both at the same clock edge. The timer then disarms.
- R10: If a valid command arrives in the same cycle as the tick that would fire the timeout, the command wins. There is no clear pulse, the outputs follow the command, and the timer restarts from zero.
- R11: Outputs are registered. They change at the first clock edge that samples the inputs causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer time-base strobe, one cycle wide |
| cmd_valid | input | 1 | Completed-packet strobe |
| cmd_code | input | 3 | Command value, sampled while cmd_valid is high |
| line_q | output | 4 | Registered one-hot output lines |
| rx_clear | output | 1 | One-cycle pulse that resets the receiver after a timeout |

## Verification
The bench builds the block with TICK_W = 2 and TIMEOUT_PERIODS = 3, so a timeout takes only twelve armed ticks. This makes the following cases cheap to reach many times over: a full timeout, a restart one tick before expiry, and a command arriving on exactly the expiry tick. The wrap carry into the second stage is crossed several times per timeout, and with a threshold above one, the comparison against the second stage is exercised beyond its first value.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_LINES = 4;

  // Line index i is driven by the command value LINE_CODE[i].
  localparam logic [CODE_W-1:0] LINE_CODE [NUM_LINES] =
    '{3'b001, 3'b100, 3'b111, 3'b101};

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [NUM_LINES-1:0] lines_t;
endpackage

// File: rtl/cmdl_decode.sv
module cmdl_decode
  import cmdl_pkg::*;
(
  input  code_t  code,
  output lines_t onehot,
  output logic   known
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign onehot[i] = (code == LINE_CODE[i]);
  end
  assign known = |onehot;
endmodule

// File: rtl/cmdl_timer.sv
module cmdl_timer #(
  parameter int TICK_W          = 8,
  parameter int TIMEOUT_PERIODS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic fire,
  output logic clr_pulse
);
  localparam int HI_W = (TIMEOUT_PERIODS < 2) ? 1 : $clog2(TIMEOUT_PERIODS);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(TIMEOUT_PERIODS - 1);

  logic [TICK_W-1:0] lo_cnt;
  logic [HI_W-1:0]   hi_cnt;
  logic              armed;
  logic              lo_wrap;

  assign lo_wrap = &lo_cnt;
  assign fire    = armed & tick & ~restart & lo_wrap & (hi_cnt == HI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      armed     <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= fire;
      if (restart) begin
        lo_cnt <= '0;
        hi_cnt <= '0;
        armed  <= 1'b1;
      end else if (fire) begin
        lo_cnt <= '0;
        hi_cnt <= '0;
        armed  <= 1'b0;
      end else if (armed && tick) begin
        lo_cnt <= lo_cnt + 1'b1;
        if (lo_wrap) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdl_outreg.sv
module cmdl_outreg
  import cmdl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  lines_t load_val,
  input  logic   wipe,
  output lines_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (wipe) q <= '0;
  end
endmodule

// File: rtl/cmd_latch_timeout.sv
module cmd_latch_timeout #(
  parameter int TICK_W          = 8,
  parameter int TIMEOUT_PERIODS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic [3:0] line_q,
  output logic       rx_clear
);
  import cmdl_pkg::*;

  lines_t dec_lines;
  logic   dec_known;
  logic   tmr_fire;

  cmdl_decode u_dec (
    .code   (cmd_code),
    .onehot (dec_lines),
    .known  (dec_known)
  );

  cmdl_timer #(
    .TICK_W          (TICK_W),
    .TIMEOUT_PERIODS (TIMEOUT_PERIODS)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (cmd_valid),
    .fire      (tmr_fire),
    .clr_pulse (rx_clear)
  );

  cmdl_outreg u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_valid & dec_known),
    .load_val (dec_lines),
    .wipe     (tmr_fire),
    .q        (line_q)
  );
endmodule

// File: rtl/cmd_latch_timeout_chk.sv
module cmd_latch_timeout_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic [3:0] line_q,
  input logic       rx_clear
);
  a_r7_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_q));

  a_r2_code_one: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 3'b001) |=> line_q == 4'b0001);

  a_r5_code_five: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 3'b101) |=> line_q == 4'b1000);

  a_r6_unknown_holds: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 3'b000 || cmd_code == 3'b010 ||
                   cmd_code == 3'b011 || cmd_code == 3'b110))
    |=> $stable(line_q));

  a_r9_clear_single: assert property (@(posedge clk) disable iff (rst)
    rx_clear |=> !rx_clear);

  a_r9_clear_lines_low: assert property (@(posedge clk) disable iff (rst)
    rx_clear |-> line_q == 4'b0000);

  a_r10_valid_no_clear: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !rx_clear);

  a_r8_no_tick_no_change: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !tick) |=> ($stable(line_q) && !rx_clear));
endmodule

bind cmd_latch_timeout cmd_latch_timeout_chk u_chk (.*);

// File: tb/cmd_latch_timeout_bench.sv
`timescale 1ns/1ps
module cmd_latch_timeout_bench;
  localparam int TW = 2;
  localparam int TP = 3;
  localparam int LIMIT = TP * (1 << TW);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'b000;
  logic [3:0] line_q;
  logic       rx_clear;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int         m_count = 0;
  bit         m_armed = 0;
  logic [3:0] m_lines = 4'b0000;
  bit         m_clr   = 0;

  always #2 clk = ~clk;

  cmd_latch_timeout #(.TICK_W(TW), .TIMEOUT_PERIODS(TP)) u_cmd_latch_timeout (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .line_q(line_q), .rx_clear(rx_clear)
  );

  task automatic model_edge();
    m_clr = 0;
    if (rst) begin
      m_count = 0; m_armed = 0; m_lines = 4'b0000;
    end else if (cmd_valid) begin
      m_armed = 1; m_count = 0;
      case (cmd_code)
        3'b001: m_lines = 4'b0001;
        3'b100: m_lines = 4'b0010;
        3'b111: m_lines = 4'b0100;
        3'b101: m_lines = 4'b1000;
        default: ;
      endcase
    end else if (m_armed && tick) begin
      m_count++;
      if (m_count == LIMIT) begin
        m_lines = 4'b0000; m_armed = 0; m_count = 0; m_clr = 1;
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [2:0] c,
                      input logic t, input string tag);
    rst = r; cmd_valid = v; cmd_code = c; tick = t;
    @(posedge clk);
    model_edge();
    #1;
    n_checks++;
    if (line_q !== m_lines || rx_clear !== m_clr) begin
      n_fail++;
      $display("FAIL %s: line_q=%b rx_clear=%b expected line_q=%b rx_clear=%b",
               tag, line_q, rx_clear, m_lines, m_clr);
    end
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3'b000, 1, tag);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 3'b000, 0, "R1");
    step(1, 1, 3'b001, 1, "R1");
    step(0, 0, 3'b000, 0, "R1");
    ticks(3 * LIMIT, "R8");                 // disarmed: no effect
    step(0, 1, 3'b001, 0, "R2");
    step(0, 0, 3'b000, 0, "R11");
    step(0, 1, 3'b100, 0, "R3");
    step(0, 1, 3'b111, 1, "R4");
    step(0, 1, 3'b101, 0, "R5");
    step(0, 1, 3'b010, 0, "R6");
    step(0, 1, 3'b000, 1, "R6");
    step(0, 1, 3'b011, 0, "R6");
    step(0, 1, 3'b110, 0, "R6");
    step(0, 1, 3'b001, 0, "R7");
    step(0, 1, 3'b111, 0, "R7");
    ticks(LIMIT - 1, "R8");
    step(0, 1, 3'b011, 0, "R6");            // unknown code re-arms
    ticks(LIMIT - 1, "R6");
    step(0, 0, 3'b000, 0, "R8");
    ticks(1, "R9");                          // expiry
    step(0, 0, 3'b000, 0, "R9");             // pulse one cycle
    ticks(2 * LIMIT, "R8");                  // disarmed after timeout
    // sparse ticks
    step(0, 1, 3'b100, 0, "R3");
    for (int i = 0; i < 4 * LIMIT; i++)
      step(0, 0, 3'b000, (i % 3 == 0), "R8");
    step(0, 0, 3'b000, 0, "R9");
    // valid on expiry tick wins
    step(0, 1, 3'b001, 0, "R10");
    ticks(LIMIT - 1, "R10");
    step(0, 1, 3'b100, 1, "R10");
    ticks(LIMIT - 1, "R10");
    ticks(1, "R9");
    ticks(3, "R8");
    // unknown code arms timer with all lines low
    step(0, 1, 3'b110, 0, "R6");
    ticks(LIMIT, "R9");
    step(0, 0, 3'b000, 0, "R9");
    // reset mid-run
    step(0, 1, 3'b101, 0, "R5");
    ticks(5, "R8");
    step(1, 0, 3'b000, 1, "R1");
    ticks(2 * LIMIT, "R1");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule